// File: doc/BRIEF.md
# Configurable UART Transmitter

This block turns bytes offered on a one-byte valid/ready holding interface into an asynchronous serial frame on a line that idles high. An external baud tick enable paces the frame: one bit lasts exactly one tick period, and a frame's start bit begins on the first tick after the byte is taken. Run-time inputs choose whether a parity bit is sent, whether that parity is even or odd, and whether one or two stop bits close the frame. These frame options are captured when a byte is accepted, so changes while a frame is in flight take effect on the next frame.

Two live controls act on the line at any moment. A break input pulls the serial stream low at once and drops the frame in progress, which is never resent. A loopback input sends the stream to a local receiver output and holds the external line idle. A clear-to-send gate can hold off new frames but never interrupts one that has started. A busy flag and a one-cycle done pulse report frame progress.

Top module: `uart_tx_engine`

## Requirements
- R1: After reset `txd` and `loop_rxd` are 1, `busy` and `done` are 0, and `tx_ready` is 1 while `brk` is 0 and the clear-to-send gate permits.
- R2: A frame is a start bit of 0, then the 8 data bits least significant first, then the stop bit(s) at 1. Every bit lasts one baud tick period, and the start bit begins on the first `baud_tick` edge after acceptance.
- R3: With `par_en`=1 one parity bit follows the last data bit; with `par_en`=0 the stop bit follows the last data bit directly.
- R4: With `par_odd`=0 the data bits plus the parity bit hold an even count of ones; with `par_odd`=1 they hold an odd count.
- R5: `two_stop`=0 sends one stop bit; `two_stop`=1 sends two.
- R6: `par_en`, `par_odd` and `two_stop` are captured when a byte is accepted; changing them during a frame does not alter that frame.
- R7: While `brk`=1 the serial stream is 0 in the same cycle, the frame in progress is abandoned (`busy` is 0 from the next cycle, no `done` pulse), and no byte is accepted. After release the stream returns to 1 and the abandoned frame is not resent.
- R8: With `cts_en`=0 the `cts` input has no effect. With `cts_en`=1 a byte is accepted only while `cts`=1; a frame already started completes even if `cts` falls.
- R9: With `loop_en`=0 the stream appears on `txd` and `loop_rxd` stays 1; with `loop_en`=1 the stream appears on `loop_rxd` and `txd` stays 1. This routing follows `loop_en` at every cycle.
- R10: `busy` is 1 from the cycle after acceptance until the baud tick that ends the last stop bit; `done` is a one-cycle pulse in the cycle after that tick, with `busy` already 0.
- R11: `tx_ready` is 1 only while no frame is in progress, `brk` is 0 and the gate permits; a byte is taken on a clock edge where `tx_valid` and `tx_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle enable marking each bit boundary |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Transmitter can take a byte this cycle |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| two_stop | input | 1 | 0 = one stop bit, 1 = two stop bits |
| brk | input | 1 | Force the stream low and abandon the frame |
| cts_en | input | 1 | Make `cts` gate the start of frames |
| cts | input | 1 | Clear to send, high permits |
| loop_en | input | 1 | Route the stream to `loop_rxd` instead of `txd` |
| txd | output | 1 | External serial line |
| loop_rxd | output | 1 | Serial stream for a local receiver |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when a frame completes |

## Verification
A wrong state in the frame engine shows on the serial line within one baud tick period: a skipped or repeated state shifts every later bit, a wrong bit counter changes the frame length, and a stale parity or stop option alters the bits after the data. A lost abort or gating decision shows at `busy` or `tx_ready` on the next clock edge. The bench therefore compares every output against a behavioural model on every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ALIGN  = 3'd1,
    ST_START  = 3'd2,
    ST_DATA   = 3'd3,
    ST_PARITY = 3'd4,
    ST_STOP1  = 3'd5,
    ST_STOP2  = 3'd6
  } tx_state_e;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
  } frame_cfg_t;

  // state that follows the first stop bit
  function automatic tx_state_e after_stop1(input frame_cfg_t cfg);
    return cfg.two_stop ? ST_STOP2 : ST_IDLE;
  endfunction

  // state that follows the last data bit
  function automatic tx_state_e after_data(input frame_cfg_t cfg);
    return cfg.par_en ? ST_PARITY : ST_STOP1;
  endfunction

endpackage

// File: rtl/uart_tx_cts_gate.sv
module uart_tx_cts_gate (
  input  logic idle,
  input  logic brk,
  input  logic cts_en,
  input  logic cts,
  input  logic valid,
  output logic ready,
  output logic accept
);
  logic send_permit;

  assign send_permit = !cts_en || cts;
  assign ready       = idle && !brk && send_permit;
  assign accept      = ready && valid;
endmodule

// File: rtl/uart_tx_sequencer.sv
module uart_tx_sequencer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              abort,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  frame_cfg_t        cfg_in,
  output logic              stream_bit,
  output logic              idle,
  output logic              frame_end
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  function automatic logic calc_parity(input logic [DATA_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  tx_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              par_q;
  frame_cfg_t        cfg_q;
  logic              done_q;
  logic              last_stop;

  assign last_stop = tick && !abort &&
                     ((state_q == ST_STOP2) ||
                      (state_q == ST_STOP1 && !cfg_q.two_stop));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      par_q   <= 1'b0;
      cfg_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_stop;
      if (abort) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (load) begin
            shreg_q <= load_data;
            par_q   <= calc_parity(load_data, cfg_in.par_odd);
            cfg_q   <= cfg_in;
            state_q <= ST_ALIGN;
          end
          ST_ALIGN: if (tick) state_q <= ST_START;
          ST_START: if (tick) begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
          end
          ST_DATA: if (tick) begin
            shreg_q <= shreg_q >> 1;
            if (cnt_q == LAST_IDX) state_q <= after_data(cfg_q);
            else                   cnt_q   <= cnt_q + 1'b1;
          end
          ST_PARITY: if (tick) state_q <= ST_STOP1;
          ST_STOP1:  if (tick) state_q <= after_stop1(cfg_q);
          ST_STOP2:  if (tick) state_q <= ST_IDLE;
          default:   state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START:  stream_bit = 1'b0;
      ST_DATA:   stream_bit = shreg_q[0];
      ST_PARITY: stream_bit = par_q;
      default:   stream_bit = 1'b1;
    endcase
  end

  assign idle      = (state_q == ST_IDLE);
  assign frame_end = done_q;
endmodule

// File: rtl/uart_tx_line_router.sv
module uart_tx_line_router (
  input  logic stream_bit,
  input  logic brk,
  input  logic loop_en,
  output logic txd,
  output logic loop_rxd
);
  logic line_val;

  assign line_val = stream_bit && !brk;
  assign txd      = loop_en ? 1'b1 : line_val;
  assign loop_rxd = loop_en ? line_val : 1'b1;
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              brk,
  input  logic              cts_en,
  input  logic              cts,
  input  logic              loop_en,
  output logic              txd,
  output logic              loop_rxd,
  output logic              busy,
  output logic              done
);
  logic       eng_idle;
  logic       accept;
  logic       stream_bit;
  frame_cfg_t cfg_now;

  assign cfg_now = '{par_en: par_en, par_odd: par_odd, two_stop: two_stop};

  uart_tx_cts_gate u_gate (
    .idle   (eng_idle),
    .brk    (brk),
    .cts_en (cts_en),
    .cts    (cts),
    .valid  (tx_valid),
    .ready  (tx_ready),
    .accept (accept)
  );

  uart_tx_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (baud_tick),
    .abort      (brk),
    .load       (accept),
    .load_data  (tx_data),
    .cfg_in     (cfg_now),
    .stream_bit (stream_bit),
    .idle       (eng_idle),
    .frame_end  (done)
  );

  uart_tx_line_router u_route (
    .stream_bit (stream_bit),
    .brk        (brk),
    .loop_en    (loop_en),
    .txd        (txd),
    .loop_rxd   (loop_rxd)
  );

  assign busy = !eng_idle;
endmodule

// File: rtl/uart_tx_engine_checks.sv
module uart_tx_engine_checks (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic brk,
  input logic cts_en,
  input logic cts,
  input logic loop_en,
  input logic accept,
  input logic tx_ready,
  input logic txd,
  input logic loop_rxd,
  input logic busy,
  input logic done
);
  assert_break_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !(txd && loop_rxd));

  assert_break_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> (!busy && !done));

  assert_loop_ext_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> txd);

  assert_loop_off_rx_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |-> loop_rxd);

  assert_cts_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (!cts_en || cts));

  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_after_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(baud_tick));

  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!busy && !brk));
endmodule

bind uart_tx_engine uart_tx_engine_checks u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .baud_tick (baud_tick),
  .brk       (brk),
  .cts_en    (cts_en),
  .cts       (cts),
  .loop_en   (loop_en),
  .accept    (accept),
  .tx_ready  (tx_ready),
  .txd       (txd),
  .loop_rxd  (loop_rxd),
  .busy      (busy),
  .done      (done)
);

// File: tb/uart_tx_engine_test.sv
`timescale 1ns/1ps
module uart_tx_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic       brk = 1'b0, cts_en = 1'b0, cts = 1'b0, loop_en = 1'b0;
  logic       txd, loop_rxd, busy, done;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_engine uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .brk(brk), .cts_en(cts_en), .cts(cts), .loop_en(loop_en),
    .txd(txd), .loop_rxd(loop_rxd), .busy(busy), .done(done)
  );

  // baud tick: one cycle in every TICK_DIV
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk); #1;
      baud_tick = (cnt == TICK_DIV - 1);
      cnt = (cnt + 1) % TICK_DIV;
    end
  end

  // behavioural reference: a queue of the bits still to go out
  bit q[$];
  bit m_busy = 0, m_pend = 0, m_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_busy = 0; m_pend = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (brk) begin
        q.delete(); m_busy = 0; m_pend = 0;
      end else if (!m_busy) begin
        if (tx_valid && (!cts_en || cts)) begin
          q.delete();
          q.push_back(1'b0);
          for (int i = 0; i < 8; i++) q.push_back(tx_data[i]);
          if (par_en) q.push_back((($countones(tx_data) % 2) == 1) ^ par_odd);
          q.push_back(1'b1);
          if (two_stop) q.push_back(1'b1);
          m_busy = 1; m_pend = 1;
        end
      end else if (baud_tick) begin
        if (m_pend) m_pend = 0;
        else begin
          void'(q.pop_front());
          if (q.size() == 0) begin m_busy = 0; m_done = 1; end
        end
      end
    end
  end

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic m_line, m_ready;
      m_line  = brk ? 1'b0 : ((m_busy && !m_pend) ? q[0] : 1'b1);
      m_ready = !m_busy && !brk && (!cts_en || cts);
      check(cur_req, "txd",      txd,      loop_en ? 1'b1 : m_line);
      check(cur_req, "loop_rxd", loop_rxd, loop_en ? m_line : 1'b1);
      check(cur_req, "busy",     busy,     m_busy);
      check(cur_req, "done",     done,     m_done);
      check(cur_req, "tx_ready", tx_ready, m_ready);
    end
  end

  task automatic send_byte(input logic [7:0] d);
    tx_data = d; tx_valid = 1'b1;
    forever begin @(negedge clk); if (tx_ready) break; end
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (!busy) break; end
    repeat (3) @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "txd", txd, 1'b1);
    check("R1", "loop_rxd", loop_rxd, 1'b1);
    check("R1", "busy", busy, 1'b0);
    check("R1", "tx_ready", tx_ready, 1'b1);

    cur_req = "R2"; send_byte(8'hA5); wait_idle();
    send_byte(8'h01); send_byte(8'h80); wait_idle();   // back to back

    cur_req = "R3"; par_en = 1; send_byte(8'h37); wait_idle();
    cur_req = "R4"; par_odd = 1; send_byte(8'h37); wait_idle();
    send_byte(8'h00); wait_idle();
    cur_req = "R5"; two_stop = 1; send_byte(8'hFF); wait_idle();
    par_en = 0; send_byte(8'h3C); wait_idle();

    // R6 controls changed mid frame
    cur_req = "R6"; par_en = 1; par_odd = 0; two_stop = 0;
    send_byte(8'hC3);
    repeat (10) @(posedge clk); #1;
    par_en = 0; par_odd = 1; two_stop = 1;
    wait_idle();
    par_en = 0; par_odd = 0; two_stop = 0;

    // R7 break during a frame
    cur_req = "R7"; send_byte(8'hFF);
    repeat (14) @(posedge clk); #1;
    brk = 1;
    @(negedge clk);
    check("R7", "txd during break", txd, 1'b0);
    repeat (8) @(posedge clk); #1;
    brk = 0;
    repeat (40) @(negedge clk);
    check("R7", "busy after release", busy, 1'b0);
    check("R7", "txd after release", txd, 1'b1);

    // R8 clear-to-send gating
    cur_req = "R8"; cts_en = 1; cts = 0;
    tx_data = 8'h96; tx_valid = 1;
    repeat (12) @(negedge clk);
    check("R8", "tx_ready blocked", tx_ready, 1'b0);
    check("R8", "busy blocked", busy, 1'b0);
    @(posedge clk); #1; cts = 1;
    forever begin @(negedge clk); if (tx_ready) break; end
    @(posedge clk); #1; tx_valid = 0;
    repeat (6) @(posedge clk); #1; cts = 0;
    wait_idle();
    check("R8", "busy after frame", busy, 1'b0);
    cts_en = 0; send_byte(8'h69); wait_idle();

    // R9 loopback
    cur_req = "R9"; loop_en = 1; send_byte(8'h5A);
    repeat (9) @(negedge clk);
    check("R9", "txd held in loopback", txd, 1'b1);
    wait_idle(); loop_en = 0;

    cur_req = "R10"; par_en = 1; two_stop = 1; send_byte(8'hE7); wait_idle();
    cur_req = "R11"; send_byte(8'h11); send_byte(8'h22); wait_idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule